// File: doc/BRIEF.md
# Compare-Match Free-Running Timer

A general-purpose timer peripheral on a simple 32-bit register bus. It holds an up-counter that advances on ticks taken from one of three clock sources. Each source is an enable strobe inside the single system clock domain: the bus clock, the peripheral clock, and a crystal-derived clock. The crystal source has its own small divider. The source that is selected then passes through a general divider before it reaches the counter.

Software schedules an event by reading the counter, adding a delta, and writing the sum into the compare register. When the counter reaches that value, a status flag is set. If the interrupt enable bit is set, the interrupt line then stays high until software clears the flag by writing a one to it. A mode bit picks what happens at a match. In restart mode the counter falls back to zero. In free-run mode it keeps counting and wraps at its maximum.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0, the counter reads 0 and `irq` is low.
- R2: Control register (offset 0x00) fields: bit 0 run, bit 3 keep counting in wait, bits 8:6 source, bit 9 free-run, bit 10 crystal enable. Source code 1 counts `bus_stb` pulses and code 2 counts `per_stb` pulses. Code 5 counts `xtal_stb` pulses, but only while bit 10 is set. Any other code stops counting, and strobes of the sources not selected have no effect.
- R3: Bits 11:0 of the divider register (offset 0x04) hold a value G. The counter advances once for every G+1 strobes of the selected source.
- R4: Bits 15:12 of the divider register hold a value X. Crystal strobes are divided by X+1 before the general divider, so the total ratio is (X+1)(G+1).
- R5: With bit 9 clear, a tick that finds the counter equal to the compare register (offset 0x10) loads the counter with 0. The period is therefore compare+1 ticks.
- R6: With bit 9 set, the counter increments through a match and wraps from its maximum value to 0.
- R7: Bit 0 of the status register (offset 0x08) is set by any tick that finds the counter equal to the compare value.
- R8: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R9: `irq` is high exactly while status bit 0 and bit 0 of the interrupt enable register (offset 0x0C) are both 1.
- R10: While control bit 0 is 0, the counter and both divider counts are held at 0. The register contents are kept.
- R11: While `wait_mode` is high and control bit 3 is 0, the counter and the dividers pause.
- R12: The counter reads at offset 0x24, and writes to that offset have no effect. Undefined bits read 0, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_stb | input | 1 | Bus-clock source strobe |
| per_stb | input | 1 | Peripheral-clock source strobe |
| xtal_stb | input | 1 | Crystal-derived source strobe |
| wait_mode | input | 1 | System is in wait mode |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Compare interrupt, level |

## Verification
The bench builds the counter 8 bits wide. It sweeps the general divider against pulse counts, so a divider that is off by one or that is not reset gives a wrong integer quotient. It also sweeps the compare value against pulse counts in restart mode, which separates the compare+1 period from a period of compare ticks, and it checks that the flag appears on exactly the first match. Free-run runs past 256 ticks with the compare value set just below the count, which shows that the counter wraps instead of restarting. The crystal path is swept over both dividers to confirm that they multiply, and the bench feeds strobes from sources that are not selected to show they are ignored.

// File: rtl/match_timer_pkg.sv
// Package: register offsets, control field positions and source codes
// shared by the timer submodules. Assumes a byte-addressed register bus.
package match_timer_pkg;
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_DIV  = 'h04;
    localparam int OFF_STAT = 'h08;
    localparam int OFF_IEN  = 'h0C;
    localparam int OFF_CMP  = 'h10;
    localparam int OFF_CNT  = 'h24;

    localparam int B_RUN     = 0;
    localparam int B_WAITRUN = 3;
    localparam int B_SRC     = 6;
    localparam int SRC_W     = 3;
    localparam int B_FREE    = 9;
    localparam int B_XEN     = 10;

    localparam logic [31:0] CTRL_MASK = 32'h0000_07C9;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_BUS  = 3'd1,
        SRC_PER  = 3'd2,
        SRC_XTAL = 3'd5
    } src_e;
endpackage

// File: rtl/match_timer_prescaler.sv
// Divide-by-(div+1) strobe divider. Emits a strobe in the same cycle as the
// input strobe that completes a group. Assumes clr is held while stopped.
module match_timer_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb_in,
    input  logic [W-1:0] div,
    output logic         stb_out
);
    logic [W-1:0] cnt_q;
    logic         last;

    // Group complete when count has reached the divide value (or passed it after a rewrite).
    assign last    = (cnt_q >= div);
    assign stb_out = stb_in && last;

    // Advance the group count on every input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (stb_in) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/match_timer_clksel.sv
// Source selection and division. The crystal strobe passes its own divider,
// then the chosen source passes the general divider to form the counter tick.
// Assumes all sources are single-cycle strobes in the clk domain.
module match_timer_clksel
    import match_timer_pkg::*;
#(
    parameter int GEN_W  = 12,
    parameter int XTAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  src_e              src,
    input  logic              xtal_en,
    input  logic              bus_stb,
    input  logic              per_stb,
    input  logic              xtal_stb,
    input  logic [GEN_W-1:0]  gen_div,
    input  logic [XTAL_W-1:0] xtal_div,
    output logic              tick
);
    logic xtal_in;
    logic xtal_div_stb;
    logic sel_stb;

    assign xtal_in = run && xtal_en && xtal_stb;

    match_timer_prescaler #(.W(XTAL_W)) xtal_pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .stb_in (xtal_in),
        .div    (xtal_div),
        .stb_out(xtal_div_stb)
    );

    // Pick the strobe of the selected source; unknown codes give none.
    always_comb begin
        case (src)
            SRC_BUS:  sel_stb = run && bus_stb;
            SRC_PER:  sel_stb = run && per_stb;
            SRC_XTAL: sel_stb = xtal_div_stb;
            default:  sel_stb = 1'b0;
        endcase
    end

    match_timer_prescaler #(.W(GEN_W)) gen_pre_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .stb_in (sel_stb),
        .div    (gen_div),
        .stb_out(tick)
    );
endmodule

// File: rtl/match_timer_counter.sv
// Up-counter with one compare channel. A tick that finds the count equal to
// the compare value raises match; in restart mode that tick loads zero.
module match_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             free_run,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;

    assign match = tick && (cnt_q == cmp);
    assign cnt   = cnt_q;

    // Count ticks; restart on match unless free-running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (match && !free_run) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/match_timer_regs.sv
// Register file: control, divider, compare, interrupt enable and the
// write-one-to-clear match flag, plus the combinational read mux.
module match_timer_regs
    import match_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int GEN_W  = 12,
    parameter int XTAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              match,
    input  logic [CNT_W-1:0]  cnt,
    output logic [31:0]       rdata,
    output logic              ctrl_run,
    output logic              ctrl_waitrun,
    output src_e              ctrl_src,
    output logic              ctrl_free,
    output logic              ctrl_xen,
    output logic [GEN_W-1:0]  gen_div,
    output logic [XTAL_W-1:0] xtal_div,
    output logic [CNT_W-1:0]  cmp,
    output logic              ien,
    output logic              flag
);
    localparam int DIV_W = GEN_W + XTAL_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

    logic [31:0]      ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cmp_q;
    logic             ien_q;
    logic             flag_q;

    assign ctrl_run     = ctrl_q[B_RUN];
    assign ctrl_waitrun = ctrl_q[B_WAITRUN];
    assign ctrl_src     = src_e'(ctrl_q[B_SRC +: SRC_W]);
    assign ctrl_free    = ctrl_q[B_FREE];
    assign ctrl_xen     = ctrl_q[B_XEN];
    assign gen_div      = div_q[GEN_W-1:0];
    assign xtal_div     = div_q[GEN_W +: XTAL_W];
    assign cmp          = cmp_q;
    assign ien          = ien_q;
    assign flag         = flag_q;

    // Writable configuration registers; undefined bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            cmp_q  <= '0;
            ien_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata & CTRL_MASK;
            if (addr == A_DIV)  div_q  <= wdata[DIV_W-1:0];
            if (addr == A_CMP)  cmp_q  <= wdata[CNT_W-1:0];
            if (addr == A_IEN)  ien_q  <= wdata[0];
        end
    end

    // Match flag: a new match wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (match) begin
            flag_q <= 1'b1;
        end else if (wr_en && addr == A_STAT && wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_DIV:   rdata = 32'(div_q);
            A_STAT:  rdata = {31'd0, flag_q};
            A_IEN:   rdata = {31'd0, ien_q};
            A_CMP:   rdata = 32'(cmp_q);
            A_CNT:   rdata = 32'(cnt);
            default: rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/match_timer.sv
// Top of the compare-match timer. Ties the register file, source/divider
// chain and counter together. Assumes one clock domain with source strobes.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int GEN_W  = 12,
    parameter int XTAL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_stb,
    input  logic              per_stb,
    input  logic              xtal_stb,
    input  logic              wait_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    logic              ctrl_en;
    logic              wait_run;
    src_e              src_sel;
    logic              free_run;
    logic              xtal_en;
    logic [GEN_W-1:0]  gen_div;
    logic [XTAL_W-1:0] xtal_div;
    logic [CNT_W-1:0]  cmp_val;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_match;
    logic              cnt_tick;
    logic              irq_en;
    logic              match_flag;
    logic              running;

    assign running = ctrl_en && (!wait_mode || wait_run);
    assign irq     = match_flag && irq_en;

    match_timer_regs #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .GEN_W(GEN_W), .XTAL_W(XTAL_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .match       (cnt_match),
        .cnt         (cnt_val),
        .rdata       (rdata),
        .ctrl_run    (ctrl_en),
        .ctrl_waitrun(wait_run),
        .ctrl_src    (src_sel),
        .ctrl_free   (free_run),
        .ctrl_xen    (xtal_en),
        .gen_div     (gen_div),
        .xtal_div    (xtal_div),
        .cmp         (cmp_val),
        .ien         (irq_en),
        .flag        (match_flag)
    );

    match_timer_clksel #(.GEN_W(GEN_W), .XTAL_W(XTAL_W)) clksel_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!ctrl_en),
        .run     (running),
        .src     (src_sel),
        .xtal_en (xtal_en),
        .bus_stb (bus_stb),
        .per_stb (per_stb),
        .xtal_stb(xtal_stb),
        .gen_div (gen_div),
        .xtal_div(xtal_div),
        .tick    (cnt_tick)
    );

    match_timer_counter #(.CNT_W(CNT_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!ctrl_en),
        .tick    (cnt_tick),
        .free_run(free_run),
        .cmp     (cmp_val),
        .cnt     (cnt_val),
        .match   (cnt_match)
    );
endmodule

// File: rtl/match_timer_checker.sv
// Checker for the timer: relates the counter, tick, flag and interrupt over
// time. Bound into every match_timer instance.
module match_timer_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             frr,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             flag,
    input logic             ie,
    input logic             irq
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (cnt == '0)); // R10
    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !tick); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (en && !tick) |=> $stable(cnt)); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (en && tick && cnt == cmp && !frr) |=> (cnt == '0)); // R5
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (en && tick && frr) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (tick && cnt == cmp) |=> flag); // R7
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(tick && cnt == cmp)); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (flag && ie)); // R9
endmodule

bind match_timer match_timer_checker #(.CNT_W(CNT_W)) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_en),
    .frr  (free_run),
    .tick (cnt_tick),
    .cnt  (cnt_val),
    .cmp  (cmp_val),
    .flag (match_flag),
    .ie   (irq_en),
    .irq  (irq)
);

// File: tb/match_timer_tb_top.sv
// Bench: 8-bit counter configuration, strobes issued one pulse at a time,
// expected values derived arithmetically from pulse counts.
module match_timer_tb_top;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;
    localparam logic [7:0] A_CTRL = 8'h00, A_DIV = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;
    localparam logic [31:0] C_EN = 32'h1, C_WAIT = 32'h8, C_FREE = 32'h200,
                            C_XEN = 32'h400;
    localparam logic [31:0] S_BUS = 32'd1 << 6, S_PER = 32'd2 << 6,
                            S_XT = 32'd5 << 6, S_BAD = 32'd3 << 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_stb = 1'b0, per_stb = 1'b0, xtal_stb = 1'b0;
    logic              wait_mode = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;
    int                n_run = 0;
    int                n_fail = 0;
    logic [31:0]       v;

    always #4 clk = ~clk;

    match_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .per_stb(per_stb),
        .xtal_stb(xtal_stb), .wait_mode(wait_mode), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulses(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            bus_stb = (which == 0); per_stb = (which == 1); xtal_stb = (which == 2);
            @(negedge clk);
            bus_stb = 1'b0; per_stb = 1'b0; xtal_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic cfg(input logic [31:0] c, input logic [31:0] d, input logic [31:0] cm);
        wr(A_CTRL, 32'd0);
        wr(A_DIV, d);
        wr(A_CMP, cm);
        wr(A_STAT, 32'd1);
        wr(A_CTRL, c);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_DIV, v);  chk("R1 div", v, 0);
        rd(A_STAT, v); chk("R1 stat", v, 0);
        rd(A_IEN, v);  chk("R1 ien", v, 0);
        rd(A_CMP, v);  chk("R1 cmp", v, 0);
        rd(A_CNT, v);  chk("R1 cnt", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R3: general divider sweep
        for (int d = 0; d < 4; d++) begin
            for (int n = 0; n < 10; n++) begin
                cfg(C_EN | S_BUS | C_FREE, d, 32'hF0);
                pulses(0, n);
                rd(A_CNT, v); chk("R3 div", v, n / (d + 1));
            end
        end

        // R5 R7: restart sweep over compare values
        for (int c = 0; c < 4; c++) begin
            for (int n = 0; n < 11; n++) begin
                cfg(C_EN | S_BUS, 0, c);
                pulses(0, n);
                rd(A_CNT, v);  chk("R5 restart cnt", v, n % (c + 1));
                rd(A_STAT, v); chk("R7 flag", v, (n >= c + 1) ? 1 : 0);
            end
        end

        // R6: free-run through match and wrap
        cfg(C_EN | S_BUS | C_FREE, 0, 32'h05);
        pulses(0, 260);
        rd(A_CNT, v);  chk("R6 wrap cnt", v, 260 % 256);
        rd(A_STAT, v); chk("R6 flag after pass", v, 1);
        wr(A_STAT, 1);
        pulses(0, 2);
        rd(A_CNT, v);  chk("R6 through match", v, 6);
        rd(A_STAT, v); chk("R7 flag free-run", v, 1);
        wr(A_STAT, 1);
        wr(A_CMP, 5);
        pulses(0, 255);
        rd(A_CNT, v);  chk("R6 near wrap cnt", v, 5);
        rd(A_STAT, v); chk("R7 no early flag", v, 0);
        pulses(0, 1);
        rd(A_STAT, v); chk("R7 flag one wrap away", v, 1);

        // R4: crystal path, both dividers
        for (int x = 0; x < 3; x++) begin
            for (int d = 0; d < 2; d++) begin
                cfg(C_EN | S_XT | C_XEN | C_FREE, (x << 12) | d, 32'hF0);
                pulses(2, 12);
                rd(A_CNT, v); chk("R4 xtal ratio", v, 12 / ((x + 1) * (d + 1)));
            end
        end
        cfg(C_EN | S_XT | C_FREE, 0, 32'hF0);
        pulses(2, 6);
        rd(A_CNT, v); chk("R2 xtal needs enable", v, 0);
        cfg(C_EN | S_XT | C_XEN | C_FREE, 0, 32'hF0);
        pulses(0, 4);
        rd(A_CNT, v); chk("R2 bus ignored on xtal", v, 0);

        // R2: peripheral source and bad code
        cfg(C_EN | S_PER | C_FREE, 1, 32'hF0);
        pulses(1, 7);
        rd(A_CNT, v); chk("R2 per source", v, 3);
        pulses(0, 5);
        pulses(2, 5);
        rd(A_CNT, v); chk("R2 others ignored", v, 3);
        cfg(C_EN | S_BAD | C_FREE, 0, 32'hF0);
        pulses(0, 4);
        rd(A_CNT, v); chk("R2 bad code", v, 0);

        // R9 R8: interrupt and write-one-to-clear
        cfg(C_EN | S_BUS, 0, 2);
        wr(A_IEN, 0);
        pulses(0, 3);
        rd(A_STAT, v); chk("R7 flag set", v, 1);
        chk("R9 irq masked", {31'd0, irq}, 0);
        wr(A_IEN, 1);
        chk("R9 irq raised", {31'd0, irq}, 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R8 zero write no effect", v, 1);
        chk("R9 irq held", {31'd0, irq}, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R8 cleared", v, 0);
        chk("R9 irq dropped", {31'd0, irq}, 0);
        wr(A_IEN, 0);

        // R10: stop clears counter and dividers, keeps registers
        cfg(C_EN | S_BUS | C_FREE, 0, 32'hF0);
        pulses(0, 9);
        rd(A_CNT, v); chk("R10 pre-stop", v, 9);
        cfg(C_EN | S_BUS | C_FREE, 3, 32'hF0);
        pulses(0, 2);
        wr(A_CTRL, 0);
        rd(A_CNT, v); chk("R10 counter cleared", v, 0);
        rd(A_DIV, v); chk("R10 div kept", v, 3);
        pulses(0, 3);
        rd(A_CNT, v); chk("R10 no count while stopped", v, 0);
        wr(A_CTRL, C_EN | S_BUS | C_FREE);
        pulses(0, 3);
        rd(A_CNT, v); chk("R10 divider restarted", v, 0);
        pulses(0, 1);
        rd(A_CNT, v); chk("R10 first tick", v, 1);

        // R11: wait mode
        cfg(C_EN | S_BUS | C_FREE, 0, 32'hF0);
        wait_mode = 1'b1;
        pulses(0, 5);
        rd(A_CNT, v); chk("R11 paused", v, 0);
        wr(A_CTRL, C_EN | S_BUS | C_FREE | C_WAIT);
        pulses(0, 5);
        rd(A_CNT, v); chk("R11 runs in wait", v, 5);
        wait_mode = 1'b0;

        // R12: counter read-only, readback masks, unmapped
        wr(A_CNT, 32'h55);
        rd(A_CNT, v); chk("R12 counter write ignored", v, 5);
        rd(8'h14, v); chk("R12 unmapped", v, 0);
        rd(8'h20, v); chk("R12 unmapped 2", v, 0);
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R12 ctrl mask", v, 32'h0000_07C9);
        wr(A_DIV, 32'hFFFF_FFFF);
        rd(A_DIV, v); chk("R12 div mask", v, 32'h0000_FFFF);
        wr(A_CMP, 32'h0000_01AB);
        rd(A_CMP, v); chk("R12 cmp width", v, 32'h0000_00AB);

        finish_run();
    end
endmodule